// File: doc/BRIEF.md
# Register-Mapped Iterative Integer Divider

This block is a bus peripheral that divides one 32-bit integer by another. A processor writes the two operands through a simple bus on which every access finishes in one cycle. After the write that completes the operands, a fixed-latency sequential datapath produces the quotient and the remainder. Software polls a status word to see when the result is ready. Each operand can be written through an unsigned alias or a signed alias, and the alias used in the most recent operand write selects the arithmetic.

The status word also carries a "live context" flag, called DIRTY. Any operand write sets it, and only a read of the quotient clears it. An interrupt handler that wants to use the divider can test this flag first. If the flag is set, the handler saves the operands, the remainder and the quotient, in that order. Afterwards it restores them by writing the registers back: the operands first, then the remainder, then the quotient. Writing the quotient or the remainder loads that value directly and stops any calculation that is running. This lets an interrupted result be put back exactly as it was.

Top module: `div_mmio`

## Requirements
- R1: The register index `bus_idx` times four gives the byte offset. The indices are: 0 unsigned dividend, 1 unsigned divisor, 2 quotient, 3 remainder, 4 signed dividend, 5 signed divisor, 6 status, and 7 reserved, which reads zero. Both aliases of an operand read back the stored operand value.
- R2: A write to an operand alias starts a new division using the stored value of the other operand. The division is signed when that write used index 4 or 5, and unsigned when it used index 0 or 1.
- R3: READY reads 1 again exactly 8 rising clock edges after the edge that sampled the last operand write. From then on, the quotient and remainder hold their values until the next write.
- R4: An operand write sets DIRTY and clears READY, both on the edge that samples it. A write that arrives during a calculation discards that calculation and starts again from 8 cycles.
- R5: A read of index 2 clears DIRTY. No read ever waits. Reading the quotient before READY returns a partial value and does not disturb the final result.
- R6: Unsigned mode gives the floor quotient and the remainder. Signed mode truncates toward zero, and the remainder takes the sign of the dividend. 0x80000000 divided by -1 gives quotient 0x80000000 and remainder 0.
- R7: A write to index 2 or 3 loads that register and stops any calculation. READY becomes 1 on the next edge, and DIRTY keeps its value.
- R8: In the status word, bit 0 is READY and bit 1 is DIRTY. All other bits read 0, and writes to the status word change nothing.
- R9: With a zero divisor, the remainder equals the dividend. In unsigned mode the quotient is 0xFFFFFFFF. In signed mode the quotient is -1 for a dividend of zero or more, and +1 for a negative dividend.
- R10: After reset, READY is 1, DIRTY is 0, and the operands, quotient and remainder are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_rd | input | 1 | Read strobe; its side effect happens on the rising edge |
| bus_idx | input | 3 | Register index (byte offset divided by four) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_idx` in the same cycle |

## Verification
Read data is combinational, so register values are compared during the same cycle as the read. Status changes caused by a write or a quotient read appear after the edge that samples the access. The final result and READY=1 appear 8 edges after the last operand write. The reference model in the bench counts down those edges itself and reads the status word on every idle cycle. This means an early or late READY is caught at the exact cycle where it goes wrong. Quotient and remainder values are compared only once the model knows them, that is, after completion or after a direct load.

// File: rtl/div_pkg.sv
// Package div_pkg: shared register indices and status bit positions.
// Assumes one access per cycle and word-granular register indexing.
package div_pkg;

    typedef enum logic [2:0] {
        RI_UDVD = 3'd0,
        RI_UDVS = 3'd1,
        RI_QUOT = 3'd2,
        RI_REM  = 3'd3,
        RI_SDVD = 3'd4,
        RI_SDVS = 3'd5,
        RI_STAT = 3'd6,
        RI_RSVD = 3'd7
    } reg_idx_e;

    localparam int STAT_READY_BIT = 0;
    localparam int STAT_DIRTY_BIT = 1;

endpackage

// File: rtl/div_regs.sv
// Module div_regs: decodes bus accesses, holds the operand registers and
// the DIRTY flag, and hands the next-operand values to the datapath.
// Assumes the bus never issues a write and a quotient read in the same cycle.
module div_regs
    import div_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bus_wr,
    input  logic         bus_rd,
    input  reg_idx_e     idx,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] dvd_q,
    output logic [W-1:0] dvs_q,
    output logic [W-1:0] nxt_dvd,
    output logic [W-1:0] nxt_dvs,
    output logic         nxt_signed,
    output logic         start,
    output logic         load_quot,
    output logic         load_rem,
    output logic         dirty_q
);

    logic wr_dvd, wr_dvs, rd_quot;

    // Decode the write and read strobes for each register.
    always_comb begin
        wr_dvd     = bus_wr && (idx == RI_UDVD || idx == RI_SDVD);
        wr_dvs     = bus_wr && (idx == RI_UDVS || idx == RI_SDVS);
        start      = wr_dvd || wr_dvs;
        nxt_signed = (idx == RI_SDVD) || (idx == RI_SDVS);
        load_quot  = bus_wr && (idx == RI_QUOT);
        load_rem   = bus_wr && (idx == RI_REM);
        rd_quot    = bus_rd && (idx == RI_QUOT);
        nxt_dvd    = wr_dvd ? wdata : dvd_q;
        nxt_dvs    = wr_dvs ? wdata : dvs_q;
    end

    // Store the operands; an operand write sets DIRTY, a quotient read clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dvd_q   <= '0;
            dvs_q   <= '0;
            dirty_q <= 1'b0;
        end else begin
            dvd_q <= nxt_dvd;
            dvs_q <= nxt_dvs;
            if (start)        dirty_q <= 1'b1;
            else if (rd_quot) dirty_q <= 1'b0;
        end
    end

    p_dirty_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> dirty_q);
    p_dirty_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_quot && !start) |=> !dirty_q);
    p_load_keeps_dirty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (load_quot || load_rem) |=> $stable(dirty_q));

endmodule

// File: rtl/div_core.sv
// Module div_core: restoring divider that retires W/CYCLES quotient bits
// per clock. While it runs, quot_q and rem_q hold the partial magnitudes;
// the signs are applied on the last step. Assumes W is a multiple of CYCLES.
module div_core #(
    parameter int W      = 32,
    parameter int CYCLES = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] nxt_dvd,
    input  logic [W-1:0] nxt_dvs,
    input  logic         nxt_signed,
    input  logic         load_quot,
    input  logic         load_rem,
    input  logic [W-1:0] load_data,
    output logic [W-1:0] quot_q,
    output logic [W-1:0] rem_q,
    output logic         ready_q
);

    localparam int STEP  = W / CYCLES;
    localparam int CNT_W = $clog2(CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [W-1:0]     dvs_mag_q;
    logic             neg_quot_q, neg_rem_q;
    logic [W-1:0]     acc_c [STEP+1];
    logic [W-1:0]     qs_c  [STEP+1];

    // Absolute value of an operand when the division is signed.
    function automatic logic [W-1:0] mag_of(input logic [W-1:0] v, input logic s);
        return (s && v[W-1]) ? (~v + 1'b1) : v;
    endfunction

    assign acc_c[0] = rem_q;
    assign qs_c[0]  = quot_q;

    for (genvar i = 0; i < STEP; i++) begin : g_step
        logic [W:0]   trial;
        logic [W-1:0] diff;
        logic         take;
        // One restoring step: shift in the next dividend bit, subtract if it fits.
        always_comb begin
            trial        = {acc_c[i], qs_c[i][W-1]};
            take         = trial >= {1'b0, dvs_mag_q};
            diff         = trial[W-1:0] - dvs_mag_q;
            acc_c[i+1]   = take ? diff : trial[W-1:0];
            qs_c[i+1]    = {qs_c[i][W-2:0], take};
        end
    end

    // Sequence the calculation: start, direct loads, steps, and the sign fix.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            quot_q     <= '0;
            rem_q      <= '0;
            dvs_mag_q  <= '0;
            neg_quot_q <= 1'b0;
            neg_rem_q  <= 1'b0;
            ready_q    <= 1'b1;
        end else if (start) begin
            cnt_q      <= CNT_W'(CYCLES);
            quot_q     <= mag_of(nxt_dvd, nxt_signed);
            rem_q      <= '0;
            dvs_mag_q  <= mag_of(nxt_dvs, nxt_signed);
            neg_quot_q <= nxt_signed && (nxt_dvd[W-1] ^ nxt_dvs[W-1]);
            neg_rem_q  <= nxt_signed && nxt_dvd[W-1];
            ready_q    <= 1'b0;
        end else if (load_quot || load_rem) begin
            cnt_q   <= '0;
            ready_q <= 1'b1;
            if (load_quot) quot_q <= load_data;
            if (load_rem)  rem_q  <= load_data;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CNT_W'(1)) begin
                quot_q  <= neg_quot_q ? (~qs_c[STEP] + 1'b1) : qs_c[STEP];
                rem_q   <= neg_rem_q  ? (~acc_c[STEP] + 1'b1) : acc_c[STEP];
                ready_q <= 1'b1;
            end else begin
                quot_q <= qs_c[STEP];
                rem_q  <= acc_c[STEP];
            end
        end
    end

    p_start_clears_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !ready_q);
    p_last_step_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_W'(1) && !start) |=> ready_q);
    p_quot_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (load_quot && !start) |=> (ready_q && quot_q == $past(load_data)));
    p_result_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_q && !start && !load_quot && !load_rem) |=> ($stable(quot_q) && $stable(rem_q)));

endmodule

// File: rtl/div_mmio.sv
// Module div_mmio: top of the register-mapped divider. It joins the
// register/decode block to the datapath and forms the read data from the
// register index in the same cycle. Assumes single-cycle accesses.
module div_mmio
    import div_pkg::*;
#(
    parameter int W      = 32,
    parameter int CYCLES = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bus_wr,
    input  logic         bus_rd,
    input  logic [2:0]   bus_idx,
    input  logic [W-1:0] bus_wdata,
    output logic [W-1:0] bus_rdata
);

    reg_idx_e     idx;
    logic [W-1:0] dvd_q, dvs_q, nxt_dvd, nxt_dvs, quot_q, rem_q;
    logic         nxt_signed, start, load_quot, load_rem, dirty_q, ready_q;
    logic [W-1:0] status_w;

    assign idx = reg_idx_e'(bus_idx);

    div_regs #(.W(W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .idx(idx), .wdata(bus_wdata), .dvd_q(dvd_q), .dvs_q(dvs_q),
        .nxt_dvd(nxt_dvd), .nxt_dvs(nxt_dvs), .nxt_signed(nxt_signed),
        .start(start), .load_quot(load_quot), .load_rem(load_rem),
        .dirty_q(dirty_q)
    );

    div_core #(.W(W), .CYCLES(CYCLES)) u_core (
        .clk(clk), .rst_n(rst_n), .start(start), .nxt_dvd(nxt_dvd),
        .nxt_dvs(nxt_dvs), .nxt_signed(nxt_signed), .load_quot(load_quot),
        .load_rem(load_rem), .load_data(bus_wdata), .quot_q(quot_q),
        .rem_q(rem_q), .ready_q(ready_q)
    );

    // Assemble the status word from the two flags.
    always_comb begin
        status_w                 = '0;
        status_w[STAT_READY_BIT] = ready_q;
        status_w[STAT_DIRTY_BIT] = dirty_q;
    end

    // Select read data from the register index.
    always_comb begin
        case (idx)
            RI_UDVD, RI_SDVD: bus_rdata = dvd_q;
            RI_UDVS, RI_SDVS: bus_rdata = dvs_q;
            RI_QUOT:          bus_rdata = quot_q;
            RI_REM:           bus_rdata = rem_q;
            RI_STAT:          bus_rdata = status_w;
            default:          bus_rdata = '0;
        endcase
    end

    p_status_write_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && idx == RI_STAT && !bus_rd) |=> $stable(dirty_q));

endmodule

// File: tb/div_mmio_test.sv
// Bench for div_mmio: behavioural reference model stepped on every clock.
module div_mmio_test;

    localparam logic [2:0] I_UDVD = 3'd0, I_UDVS = 3'd1, I_QUOT = 3'd2,
                           I_REM = 3'd3, I_SDVD = 3'd4, I_SDVS = 3'd5,
                           I_STAT = 3'd6, I_RSVD = 3'd7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]  bus_idx = I_STAT;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int checks = 0;
    int errors = 0;

    // Reference model state.
    logic [31:0] m_dvd = '0, m_dvs = '0, m_quot = '0, m_rem = '0;
    bit m_sgn = 0, m_ready = 1, m_dirty = 0, m_qk = 1, m_rk = 1;
    int m_cnt = 0;

    always #10 clk = ~clk;

    div_mmio uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_idx(bus_idx), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic ref_div(input bit s, input logic [31:0] a, input logic [31:0] b,
                           output logic [31:0] q, output logic [31:0] r);
        int sa, sb;
        sa = a; sb = b;
        if (b == 0) begin
            r = a;
            q = s ? (a[31] ? 32'd1 : 32'hFFFF_FFFF) : 32'hFFFF_FFFF;
        end else if (!s) begin
            q = a / b; r = a % b;
        end else if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) begin
            q = 32'h8000_0000; r = 0;
        end else begin
            q = sa / sb; r = sa % sb;
        end
    endtask

    // One bus cycle: drive at the falling edge, compare reads, step the model at the rising edge.
    task automatic access(input bit wr, input bit rd, input logic [2:0] idx,
                          input logic [31:0] data, input string tag);
        logic [31:0] q, r;
        @(negedge clk);
        bus_wr = wr; bus_rd = rd; bus_idx = idx; bus_wdata = data;
        #1;
        if (rd) begin
            case (idx)
                I_UDVD, I_SDVD: chk(tag, bus_rdata, m_dvd);
                I_UDVS, I_SDVS: chk(tag, bus_rdata, m_dvs);
                I_QUOT: if (m_qk) chk(tag, bus_rdata, m_quot);
                I_REM:  if (m_rk) chk(tag, bus_rdata, m_rem);
                I_STAT: chk(tag, bus_rdata, {30'd0, m_dirty, m_ready});
                default: chk(tag, bus_rdata, 32'd0);
            endcase
        end
        @(posedge clk);
        if (m_cnt > 0) begin
            m_cnt--;
            if (m_cnt == 0) begin
                ref_div(m_sgn, m_dvd, m_dvs, q, r);
                m_quot = q; m_rem = r; m_qk = 1; m_rk = 1; m_ready = 1;
            end
        end
        if (wr) begin
            case (idx)
                I_UDVD, I_SDVD, I_UDVS, I_SDVS: begin
                    if (idx == I_UDVD || idx == I_SDVD) m_dvd = data; else m_dvs = data;
                    m_sgn = (idx == I_SDVD || idx == I_SDVS);
                    m_cnt = 8; m_ready = 0; m_dirty = 1; m_qk = 0; m_rk = 0;
                end
                I_QUOT: begin
                    m_quot = data; m_qk = 1; if (m_cnt != 0) m_rk = 0;
                    m_cnt = 0; m_ready = 1;
                end
                I_REM: begin
                    m_rem = data; m_rk = 1; if (m_cnt != 0) m_qk = 0;
                    m_cnt = 0; m_ready = 1;
                end
                default: ;
            endcase
        end else if (rd && idx == I_QUOT) begin
            m_dirty = 0;
        end
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) access(0, 1, I_STAT, 32'd0, tag);
    endtask

    // Full division: write both operands, wait, read remainder then quotient.
    task automatic divide(input bit s, input logic [31:0] a, input logic [31:0] b, input string tag);
        access(1, 0, s ? I_SDVD : I_UDVD, a, tag);
        access(1, 0, s ? I_SDVS : I_UDVS, b, tag);
        idle(9, {tag, " R3 status timing"});
        access(0, 1, I_REM, 0, {tag, " remainder"});
        access(0, 1, I_QUOT, 0, {tag, " quotient"});
        idle(1, {tag, " R5 dirty cleared"});
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R10 reset state
        access(0, 1, I_STAT, 0, "R10 status");
        access(0, 1, I_QUOT, 0, "R10 quotient");
        access(0, 1, I_REM, 0, "R10 remainder");
        access(0, 1, I_UDVD, 0, "R10 dividend");
        access(0, 1, I_SDVS, 0, "R10 divisor");
        access(0, 1, I_RSVD, 0, "R1 reserved");
        // R2 R6 unsigned and signed results
        divide(0, 32'd100, 32'd7, "R6 unsigned 100/7");
        divide(1, -32'sd100, 32'd7, "R6 signed -100/7");
        divide(1, 32'd100, -32'sd7, "R6 signed 100/-7");
        divide(1, -32'sd100, -32'sd7, "R6 signed -100/-7");
        divide(0, 32'hFFFF_FFFF, 32'd1, "R6 unsigned max/1");
        divide(0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R6 unsigned max/max");
        divide(0, 32'h1234_5678, 32'h0000_9ABC, "R6 unsigned mixed");
        divide(1, 32'h8000_0000, 32'hFFFF_FFFF, "R6 signed overflow");
        divide(0, 32'hF000_0000, 32'd3, "R2 unsigned big dividend");
        // R9 divide by zero
        divide(0, 32'd55, 32'd0, "R9 unsigned by zero");
        divide(1, 32'd55, 32'd0, "R9 signed positive by zero");
        divide(1, -32'sd55, 32'd0, "R9 signed negative by zero");
        // R1 R2 aliases: read back, last alias picks mode
        access(1, 0, I_UDVD, -32'sd20, "R2 alias");
        access(1, 0, I_SDVS, 32'd6, "R2 alias");
        access(0, 1, I_SDVD, 0, "R1 dividend alias readback");
        access(0, 1, I_UDVS, 0, "R1 divisor alias readback");
        idle(8, "R2 alias wait");
        access(0, 1, I_QUOT, 0, "R2 signed via last alias");
        access(0, 1, I_REM, 0, "R2 remainder via last alias");
        // R4 restart mid-calculation
        access(1, 0, I_UDVD, 32'd1000, "R4 restart");
        access(1, 0, I_UDVS, 32'd3, "R4 restart");
        idle(3, "R4 busy");
        access(1, 0, I_UDVS, 32'd9, "R4 rewrite divisor");
        idle(9, "R4 R3 restarted timing");
        access(0, 1, I_QUOT, 0, "R4 restarted quotient");
        access(0, 1, I_REM, 0, "R4 restarted remainder");
        // R5 quotient read while busy
        access(1, 0, I_UDVD, 32'd77777, "R5 busy read");
        access(1, 0, I_UDVS, 32'd13, "R5 busy read");
        idle(2, "R5 busy");
        access(0, 1, I_QUOT, 0, "R5 partial read");
        idle(7, "R5 dirty clear while busy");
        access(0, 1, I_REM, 0, "R5 final remainder");
        access(0, 1, I_QUOT, 0, "R5 final quotient");
        // R7 direct loads abort and keep DIRTY
        access(1, 0, I_UDVD, 32'd500, "R7 setup");
        access(1, 0, I_UDVS, 32'd7, "R7 setup");
        idle(2, "R7 busy");
        access(1, 0, I_QUOT, 32'hCAFE_0001, "R7 quotient load");
        idle(3, "R7 ready and dirty");
        access(0, 1, I_QUOT, 0, "R7 loaded quotient");
        access(1, 0, I_REM, 32'h0000_BEEF, "R7 remainder load");
        access(0, 1, I_REM, 0, "R7 loaded remainder");
        idle(1, "R7 status after load");
        // R8 status write ignored
        access(1, 0, I_SDVD, 32'd9, "R8 setup");
        access(1, 0, I_STAT, 32'hFFFF_FFFF, "R8 status write");
        idle(1, "R8 status unchanged");
        access(1, 0, I_STAT, 32'd0, "R8 status write zero");
        idle(9, "R8 status after write");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 200000);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule